// File: doc/BRIEF.md
# CPU Interrupt Acceptance Unit

This block sits beside the instruction sequencer of an 8-bit CPU core. At every instruction boundary it decides whether the core should enter a non-maskable interrupt (NMI) service sequence, a maskable interrupt (INT) service sequence, or neither. It also holds the two interrupt-enable flip-flops, IFF1 and IFF2. The sequencer tells the block where instructions end, whether the byte just finished was a prefix, and when DI or EI executes. It also provides the M1 T2 timing strobe and an acknowledge. The block returns one take flag for each interrupt kind, plus the enable state.

The NMI pin is captured on its falling edge with no clock involved, so a pulse shorter than a clock period is still caught. The event is then brought into the clock domain through a synchroniser whose depth is a parameter (default two stages). From there it waits in a pending flag until a boundary is allowed to accept it. The INT pin is a level that is assumed synchronous to `clk`. It is looked at only in the last clock of an instruction, so a request that goes away earlier is lost. EI takes effect late, at the next instruction's M1 T2 falling-edge strobe, but it never holds back an NMI. All control pins are plain levels or one-cycle pulses. There is no data stream and no handshake.

Top module: `irq_accept`

## Requirements
- R1: While `rst_n` is low and right after it rises, `nmi_take`, `int_take`, `iff1` and `iff2` are all 0.
- R2: A falling edge on `nmi_n` is recorded even if the pin returns high before the next clock edge. If `last_cyc` is held at 1 with `prefix_op` at 0, `nmi_take` reads 0 after the first, second and third rising `clk` edges following the fall and reads 1 after the fourth.
- R3: `nmi_take` and `int_take` change only on a clock where `last_cyc`=1 and `prefix_op`=0 (an open boundary); the only exception is the acknowledge clear in R12. `nmi_take` stays 1 until the next open boundary and then drops if no new NMI edge has been recorded.
- R4: A clock where `last_cyc`=1 and `prefix_op`=1 is not an open boundary. A pending NMI or an asserted INT is not accepted there, and the NMI stays pending for a later open boundary.
- R5: `int_take` is set at an open boundary only if `int_n` is 0 in that clock, `iff1` is 1, and no NMI is pending. If INT was asserted earlier and released before the boundary, it is not taken.
- R6: When an NMI is pending and INT is asserted at the same open boundary, only `nmi_take` is set.
- R7: Accepting an NMI copies IFF1 into IFF2 and clears IFF1. If an EI is still waiting for its strobe, IFF2 becomes 1 instead and the waiting EI is cancelled.
- R8: Accepting an INT clears both IFF1 and IFF2.
- R9: A `di_pulse` clears IFF1 and IFF2 on the next clock and cancels a waiting EI.
- R10: After `ei_pulse`, IFF1 and IFF2 stay at their old values until the first `m1t2_fall` strobe, and both become 1 on that clock. An INT at an open boundary in between is not taken if IFF1 was 0.
- R11: An NMI pending at the open boundary that directly follows DI or EI, including one in the same clock as `di_pulse`, is accepted.
- R12: `ack` at 1 on a clock that is not an open boundary clears `int_take` on that clock.
- R13: A new falling edge on `nmi_n` while `nmi_take` is 1 re-arms the NMI, so `nmi_take` stays 1 across the next open boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_n | input | 1 | Non-maskable request pin, falling-edge sensitive |
| int_n | input | 1 | Maskable request pin, active-low level |
| last_cyc | input | 1 | High in the final clock of an instruction |
| prefix_op | input | 1 | The instruction ending now is a prefix byte |
| di_pulse | input | 1 | One-cycle pulse when DI executes |
| ei_pulse | input | 1 | One-cycle pulse when EI executes |
| m1t2_fall | input | 1 | Strobe marking the falling edge of T2 in an M1 cycle |
| ack | input | 1 | Sequencer has consumed the maskable take flag |
| nmi_take | output | 1 | NMI accepted; held until the next open boundary |
| int_take | output | 1 | INT accepted; held until ack or the next open boundary |
| iff1 | output | 1 | Interrupt enable flip-flop 1 |
| iff2 | output | 1 | Interrupt enable flip-flop 2 |

## Verification
Some events can land in the same clock, and the tests provoke each pair on purpose. A DI pulse can fall in the same clock as an open boundary that accepts a pending NMI: the bench expects the NMI to be taken while both enables end at 0. A pending NMI can also meet an asserted INT at one boundary: the bench expects only the NMI flag, with IFF1 copied into IFF2. A waiting EI can be overtaken by an NMI acceptance: the bench expects IFF2 at 1, and IFF1 still at 0 after the later M1 T2 strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Outcome of one boundary decision
  typedef enum logic [1:0] {
    TAKE_NONE = 2'd0,
    TAKE_NMI  = 2'd1,
    TAKE_INT  = 2'd2
  } take_e;

  typedef struct packed {
    logic en1;
    logic en2;
  } iff_t;
endpackage

// File: rtl/nmi_capture.sv
module nmi_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic accept,
  output logic pending
);
  localparam int LAST = SYNC_STAGES - 1;

  logic             edge_tog;
  logic [LAST:0]    sync_q;
  logic             seen_q;
  logic             evt;

  // Toggles on every falling pin edge, independent of clk
  always_ff @(negedge nmi_n or negedge rst_n) begin
    if (!rst_n) edge_tog <= 1'b0;
    else        edge_tog <= ~edge_tog;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= edge_tog;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[LAST-1:0], edge_tog};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= sync_q[LAST];
  end

  assign evt = sync_q[LAST] ^ seen_q;

  // A new edge wins over a simultaneous acceptance (re-arm)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= evt | (pending & ~accept);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic  last_cyc,
  input  logic  prefix_op,
  input  logic  nmi_pend,
  input  logic  int_req,
  input  logic  en1,
  output logic  open_bnd,
  output take_e sel
);
  assign open_bnd = last_cyc & ~prefix_op;

  always_comb begin
    sel = TAKE_NONE;
    if (open_bnd) begin
      if (nmi_pend)            sel = TAKE_NMI;
      else if (int_req && en1) sel = TAKE_INT;
    end
  end
endmodule

// File: rtl/iff_ctrl.sv
module iff_ctrl
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  di_pulse,
  input  logic  ei_pulse,
  input  logic  m1t2_fall,
  input  take_e sel,
  output iff_t  state
);
  logic ei_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= '0;
      ei_wait <= 1'b0;
    end else if (di_pulse) begin
      state   <= '0;
      ei_wait <= 1'b0;
    end else if (sel == TAKE_NMI) begin
      state.en2 <= state.en1 | ei_wait | ei_pulse;
      state.en1 <= 1'b0;
      ei_wait   <= 1'b0;
    end else if (sel == TAKE_INT) begin
      state   <= '0;
      ei_wait <= ei_pulse;
    end else begin
      if (m1t2_fall && ei_wait) begin
        state   <= '{en1: 1'b1, en2: 1'b1};
        ei_wait <= 1'b0;
      end
      if (ei_pulse) ei_wait <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic int_n,
  input  logic last_cyc,
  input  logic prefix_op,
  input  logic di_pulse,
  input  logic ei_pulse,
  input  logic m1t2_fall,
  input  logic ack,
  output logic nmi_take,
  output logic int_take,
  output logic iff1,
  output logic iff2
);
  logic  nmi_pend;
  logic  open_bnd;
  take_e sel;
  iff_t  en;

  nmi_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_n  (nmi_n),
    .accept (sel == TAKE_NMI),
    .pending(nmi_pend)
  );

  irq_arbiter u_arb (
    .last_cyc (last_cyc),
    .prefix_op(prefix_op),
    .nmi_pend (nmi_pend),
    .int_req  (~int_n),
    .en1      (en.en1),
    .open_bnd (open_bnd),
    .sel      (sel)
  );

  iff_ctrl u_iff (
    .clk      (clk),
    .rst_n    (rst_n),
    .di_pulse (di_pulse),
    .ei_pulse (ei_pulse),
    .m1t2_fall(m1t2_fall),
    .sel      (sel),
    .state    (en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_take <= 1'b0;
      int_take <= 1'b0;
    end else if (open_bnd) begin
      nmi_take <= (sel == TAKE_NMI);
      int_take <= (sel == TAKE_INT);
    end else if (ack) begin
      int_take <= 1'b0;
    end
  end

  assign iff1 = en.en1;
  assign iff2 = en.en2;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk (
  input logic clk,
  input logic rst_n,
  input logic last_cyc,
  input logic prefix_op,
  input logic di_pulse,
  input logic m1t2_fall,
  input logic ack,
  input logic nmi_take,
  input logic int_take,
  input logic iff1,
  input logic iff2
);
  // R3
  hold_between_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_cyc |=> $stable(nmi_take));

  // R4
  prefix_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cyc && prefix_op) |=> $stable(nmi_take));

  // R6
  single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_take && int_take));

  // R8
  int_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_take) |-> (!iff1 && !iff2));

  // R9
  di_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    di_pulse |=> (!iff1 && !iff2));

  // R10
  en_rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iff1) |-> $past(m1t2_fall));

  // R12
  ack_drops_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !last_cyc) |=> !int_take);
endmodule

bind irq_accept irq_accept_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .last_cyc (last_cyc),
  .prefix_op(prefix_op),
  .di_pulse (di_pulse),
  .m1t2_fall(m1t2_fall),
  .ack      (ack),
  .nmi_take (nmi_take),
  .int_take (int_take),
  .iff1     (iff1),
  .iff2     (iff2)
);

// File: tb/sim_irq_accept.sv
`timescale 1ns/1ps
module sim_irq_accept;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_n = 1'b1, int_n = 1'b1;
  logic last_cyc = 1'b0, prefix_op = 1'b0;
  logic di_pulse = 1'b0, ei_pulse = 1'b0, m1t2_fall = 1'b0, ack = 1'b0;
  logic nmi_take, int_take, iff1, iff2;
  int   n_chk = 0;
  int   n_bad = 0;

  always #4 clk = ~clk;

  irq_accept u0 (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .int_n(int_n),
    .last_cyc(last_cyc), .prefix_op(prefix_op), .di_pulse(di_pulse),
    .ei_pulse(ei_pulse), .m1t2_fall(m1t2_fall), .ack(ack),
    .nmi_take(nmi_take), .int_take(int_take), .iff1(iff1), .iff2(iff2)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; nmi_n = 1'b1; int_n = 1'b1; last_cyc = 1'b0; prefix_op = 1'b0;
    di_pulse = 1'b0; ei_pulse = 1'b0; m1t2_fall = 1'b0; ack = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic nmi_pulse();
    nmi_n = 1'b0;
    #1 nmi_n = 1'b1;
  endtask

  task automatic arm_nmi();
    nmi_pulse();
    repeat (3) tick();
  endtask

  task automatic boundary();
    last_cyc = 1'b1; tick(); last_cyc = 1'b0;
  endtask

  task automatic enable_ints();
    ei_pulse = 1'b1; tick(); ei_pulse = 1'b0;
    m1t2_fall = 1'b1; tick(); m1t2_fall = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; #1;
    chk("R1 nmi_take in reset", nmi_take, 1'b0);
    chk("R1 iff1 in reset", iff1, 1'b0);
    do_reset();
    chk("R1 nmi_take", nmi_take, 1'b0);
    chk("R1 int_take", int_take, 1'b0);
    chk("R1 iff1", iff1, 1'b0);
    chk("R1 iff2", iff2, 1'b0);
  endtask

  task automatic t_latency();
    do_reset();
    last_cyc = 1'b1;
    nmi_pulse();
    tick(); chk("R2 edge+1", nmi_take, 1'b0);
    tick(); chk("R2 edge+2", nmi_take, 1'b0);
    tick(); chk("R2 edge+3", nmi_take, 1'b0);
    tick(); chk("R2 edge+4", nmi_take, 1'b1);
    tick(); chk("R3 drop at next boundary", nmi_take, 1'b0);
    last_cyc = 1'b0;
  endtask

  task automatic t_hold_prefix();
    do_reset();
    arm_nmi();
    repeat (3) tick();
    chk("R3 no boundary no take", nmi_take, 1'b0);
    last_cyc = 1'b1; prefix_op = 1'b1; tick(); last_cyc = 1'b0; prefix_op = 1'b0;
    chk("R4 prefix boundary blocks", nmi_take, 1'b0);
    boundary();
    chk("R4 taken at later open boundary", nmi_take, 1'b1);
    repeat (3) tick();
    chk("R3 held between boundaries", nmi_take, 1'b1);
    boundary();
    chk("R3 cleared at next boundary", nmi_take, 1'b0);
  endtask

  task automatic t_int_basic();
    do_reset();
    ei_pulse = 1'b1; tick(); ei_pulse = 1'b0;
    chk("R10 iff1 waits for strobe", iff1, 1'b0);
    int_n = 1'b0; boundary();
    chk("R10 no int before strobe", int_take, 1'b0);
    m1t2_fall = 1'b1; tick(); m1t2_fall = 1'b0;
    chk("R10 iff1 set on strobe", iff1, 1'b1);
    chk("R10 iff2 set on strobe", iff2, 1'b1);
    boundary();
    chk("R5 int taken", int_take, 1'b1);
    chk("R8 iff1 cleared", iff1, 1'b0);
    chk("R8 iff2 cleared", iff2, 1'b0);
    int_n = 1'b1;
    tick();
    chk("R12 held before ack", int_take, 1'b1);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R12 ack clears", int_take, 1'b0);
  endtask

  task automatic t_int_lost();
    do_reset();
    enable_ints();
    int_n = 1'b0; tick(); int_n = 1'b1; tick();
    boundary();
    chk("R5 released int lost", int_take, 1'b0);
    chk("R5 iff1 untouched", iff1, 1'b1);
  endtask

  task automatic t_priority();
    do_reset();
    enable_ints();
    arm_nmi();
    int_n = 1'b0; boundary();
    chk("R6 nmi wins", nmi_take, 1'b1);
    chk("R6 int not taken", int_take, 1'b0);
    chk("R7 iff1 cleared", iff1, 1'b0);
    chk("R7 iff2 keeps old iff1", iff2, 1'b1);
    boundary();
    chk("R6 no int with iff1 low", int_take, 1'b0);
    int_n = 1'b1;
  endtask

  task automatic t_di();
    do_reset();
    enable_ints();
    arm_nmi();
    di_pulse = 1'b1; last_cyc = 1'b1; tick(); di_pulse = 1'b0; last_cyc = 1'b0;
    chk("R11 nmi at DI boundary", nmi_take, 1'b1);
    chk("R9 iff1 after DI", iff1, 1'b0);
    chk("R9 iff2 after DI", iff2, 1'b0);
    ei_pulse = 1'b1; tick(); ei_pulse = 1'b0;
    di_pulse = 1'b1; tick(); di_pulse = 1'b0;
    m1t2_fall = 1'b1; tick(); m1t2_fall = 1'b0;
    chk("R9 DI cancels waiting EI", iff1, 1'b0);
  endtask

  task automatic t_ei_nmi();
    do_reset();
    arm_nmi();
    ei_pulse = 1'b1; tick(); ei_pulse = 1'b0;
    boundary();
    chk("R11 nmi after EI", nmi_take, 1'b1);
    chk("R7 iff2 gets deferred enable", iff2, 1'b1);
    chk("R7 iff1 clear", iff1, 1'b0);
    m1t2_fall = 1'b1; tick(); m1t2_fall = 1'b0;
    chk("R7 EI cancelled", iff1, 1'b0);
  endtask

  task automatic t_rearm();
    do_reset();
    arm_nmi();
    boundary();
    chk("R13 first take", nmi_take, 1'b1);
    arm_nmi();
    boundary();
    chk("R13 re-armed take held", nmi_take, 1'b1);
    boundary();
    chk("R13 drops after service", nmi_take, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_hold_prefix();
    t_int_basic();
    t_int_lost();
    t_priority();
    t_di();
    t_ei_nmi();
    t_rearm();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule